// File: doc/BRIEF.md
# Four-Phase Handshake Bus Read Initiator

This block is the requesting side of a bus read over a shared, self-timed bus. A read is two four-phase handshakes in a row. In the address phase the initiator drives the address and raises request, and the target answers on the acknowledge line. In the data phase the target drives data and raises its ready strobe, and the initiator answers on that same acknowledge line. Control and status pins are plain levels.

The local side takes one read command over a valid/ready pair. `cmd_ready` is high only while the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and a command offered at any other time has no effect. The result comes back as a one-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take it in the cycle it appears.

On the bus side, the bus-available level and the target's acknowledge and ready strobes are resynchronised into the local clock. The address and acknowledge drivers are given separately from their output enables, so that a pad or a tri-state wrapper can release the shared lines. A programmable wait limit lets a handshake that never arrives end in an error response.

Top module: `hs_read_init`

## Requirements
- R1: `cmd_ready` is high exactly while the block is idle. A command is taken on an edge where `cmd_valid` and `cmd_ready` are both high. A command offered while `cmd_ready` is low has no effect on any output.
- R2: After a command is taken, `bus_addr_oe`, `bus_req` and `bus_ack_oe` stay low until the synchronised `bus_free` has been seen high.
- R3: `bus_addr_oe` rises, with the taken address on `bus_addr`, one clock before `bus_req` rises. Both stay high together while the block waits for acknowledge.
- R4: `bus_req` and `bus_addr_oe` fall on the same edge, once the synchronised acknowledge is seen high. The block then waits for the synchronised acknowledge to be low.
- R5: Once acknowledge is seen low, the block enables its own acknowledge driver (`bus_ack_oe`=1) with `bus_ack_o`=0 and waits for the synchronised ready.
- R6: On synchronised ready high, `bus_data` is captured and `bus_ack_o` is driven to 1. It stays at 1 until the synchronised ready is seen low.
- R7: The block then drives `bus_ack_o`=0 for exactly one cycle. In that same cycle `rsp_valid`=1, `rsp_err`=0 and `rsp_data` holds the captured value. On the next cycle the block is idle, with all enables low.
- R8: `bus_free`, `bus_ack_i` and `bus_rdy` each pass through two flops. A change on one of them reaches the bus outputs on the third rising edge after the change.
- R9: With `cfg_wait_limit`=L and L nonzero, a wait state (waiting for free, for acknowledge high, for acknowledge low, for ready high, for ready low) that has lasted L cycles without its event leads to one cycle with `rsp_valid`=1 and `rsp_err`=1. In that cycle all enables are low, and the block is idle on the next cycle. With L=0 the block waits without limit.
- R10: Outside their phases, `bus_addr_oe` and `bus_ack_oe` are low, and the two enables are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait_limit | input | WAIT_W | Cycles allowed per wait state; 0 means no limit |
| cmd_valid | input | 1 | Read command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | ADDR_W | Address of the read |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_err | output | 1 | Result is an abort after a wait limit |
| rsp_data | output | DATA_W | Captured read data |
| bus_free | input | 1 | Bus-available level |
| bus_addr | output | ADDR_W | Address value for the shared lines |
| bus_addr_oe | output | 1 | Enable of the address driver |
| bus_req | output | 1 | Request strobe |
| bus_ack_i | input | 1 | Acknowledge line as seen on the bus |
| bus_ack_o | output | 1 | Acknowledge value driven in the data phase |
| bus_ack_oe | output | 1 | Enable of the acknowledge driver |
| bus_rdy | input | 1 | Target ready strobe |
| bus_data | input | DATA_W | Shared data lines |

## Verification
On every cycle, the assertions check the ordering relations between the bus pins. The address is enabled before and during request, and request falls together with the address enable. The two drivers never overlap, the acknowledge is not driven high while request is up, and every result is a single pulse followed by idle. Other behaviours show only in the bench's scenarios, against a target model with varied response delays: the exact three-edge synchroniser latency, data integrity end to end, the abort timing in individual wait states, the unlimited wait when the limit is zero, and a command offered while busy being dropped.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_WFREE = 4'd1,
    ST_ADDR  = 4'd2,
    ST_REQ   = 4'd3,
    ST_REL   = 4'd4,
    ST_WRDY  = 4'd5,
    ST_ACKH  = 4'd6,
    ST_ACKL  = 4'd7,
    ST_FAIL  = 4'd8
  } hs_state_e;

  // bit positions of the resynchronised strobe vector
  localparam int unsigned SYN_RDY  = 0;
  localparam int unsigned SYN_ACK  = 1;
  localparam int unsigned SYN_FREE = 2;
  localparam int unsigned SYN_W    = 3;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  localparam logic [TW-1:0] CNT_MAX = '1;
  localparam logic [TW-1:0] ONE     = TW'(1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + ONE;
  end

  assign expired = (limit != '0) && (cnt == limit - ONE);

endmodule

// File: rtl/hs_read_fsm.sv
module hs_read_fsm
  import hs_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic          free_s,
  input  logic          ack_s,
  input  logic          rdy_s,
  input  logic [DW-1:0] data_in,
  input  logic          expired,
  output logic          restart,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          cmd_ready,
  output logic          addr_oe,
  output logic          req,
  output logic          ack_oe,
  output logic          ack_o,
  output logic          rsp_valid,
  output logic          rsp_err
);

  hs_state_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (cmd_valid) nxt = ST_WFREE;
      ST_WFREE: if (free_s)    nxt = ST_ADDR;  else if (expired) nxt = ST_FAIL;
      ST_ADDR:                 nxt = ST_REQ;
      ST_REQ:   if (ack_s)     nxt = ST_REL;   else if (expired) nxt = ST_FAIL;
      ST_REL:   if (!ack_s)    nxt = ST_WRDY;  else if (expired) nxt = ST_FAIL;
      ST_WRDY:  if (rdy_s)     nxt = ST_ACKH;  else if (expired) nxt = ST_FAIL;
      ST_ACKH:  if (!rdy_s)    nxt = ST_ACKL;  else if (expired) nxt = ST_FAIL;
      ST_ACKL:                 nxt = ST_IDLE;
      ST_FAIL:                 nxt = ST_IDLE;
      default:                 nxt = ST_IDLE;
    endcase
  end

  assign restart = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && cmd_valid) addr_q <= cmd_addr;
      if (st == ST_WRDY && rdy_s)     data_q <= data_in;
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign addr_oe   = (st == ST_ADDR) || (st == ST_REQ);
  assign req       = (st == ST_REQ);
  assign ack_oe    = (st == ST_WRDY) || (st == ST_ACKH) || (st == ST_ACKL);
  assign ack_o     = (st == ST_ACKH);
  assign rsp_valid = (st == ST_ACKL) || (st == ST_FAIL);
  assign rsp_err   = (st == ST_FAIL);

endmodule

// File: rtl/hs_read_init.sv
module hs_read_init
  import hs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned WAIT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait_limit,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              bus_free,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic              bus_req,
  input  logic              bus_ack_i,
  output logic              bus_ack_o,
  output logic              bus_ack_oe,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_data
);

  logic [SYN_W-1:0] raw_in, syn_out;
  logic             restart, expired;

  assign raw_in[SYN_FREE] = bus_free;
  assign raw_in[SYN_ACK]  = bus_ack_i;
  assign raw_in[SYN_RDY]  = bus_rdy;

  hs_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (raw_in),
    .q (syn_out)
  );

  hs_wait_timer #(.TW(WAIT_W)) u_timer (
    .clk (clk),
    .rst_n (rst_n),
    .restart (restart),
    .limit (cfg_wait_limit),
    .expired (expired)
  );

  hs_read_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
    .clk (clk),
    .rst_n (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_addr (cmd_addr),
    .free_s (syn_out[SYN_FREE]),
    .ack_s (syn_out[SYN_ACK]),
    .rdy_s (syn_out[SYN_RDY]),
    .data_in (bus_data),
    .expired (expired),
    .restart (restart),
    .addr_q (bus_addr),
    .data_q (rsp_data),
    .cmd_ready (cmd_ready),
    .addr_oe (bus_addr_oe),
    .req (bus_req),
    .ack_oe (bus_ack_oe),
    .ack_o (bus_ack_o),
    .rsp_valid (rsp_valid),
    .rsp_err (rsp_err)
  );

endmodule

// File: rtl/hs_read_init_chk.sv
module hs_read_init_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic bus_addr_oe,
  input logic bus_req,
  input logic bus_ack_o,
  input logic bus_ack_oe
);

  p_req_with_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr_oe);

  p_addr_leads_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(bus_addr_oe));

  p_drop_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> !bus_addr_oe);

  p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_addr_oe && bus_ack_oe));

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_req && !bus_addr_oe && !bus_ack_oe));

  p_ack_high_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack_oe && bus_ack_o) |-> !bus_req);

  p_rsp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> cmd_ready);

  p_err_in_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && !bus_addr_oe && !bus_ack_oe && !bus_req));

endmodule

bind hs_read_init hs_read_init_chk u_chk (.*);

// File: tb/test_hs_read_init.sv
module test_hs_read_init;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lim = 8'd0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_addr = 16'd0;
  logic        bus_free = 1'b1;
  logic        tgt_ack = 1'b0;
  logic        tgt_rdy = 1'b0;
  logic [15:0] tgt_data = 16'd0;

  wire        cmd_ready, rsp_valid, rsp_err, bus_addr_oe, bus_req, bus_ack_o, bus_ack_oe;
  wire [15:0] rsp_data, bus_addr;
  wire        ack_line  = bus_ack_oe ? bus_ack_o : tgt_ack;
  wire [15:0] data_line = tgt_rdy ? tgt_data : 16'd0;

  localparam logic [15:0] KEY = 16'h5A3C;

  always #4 clk = ~clk;  // 125 MHz

  hs_read_init i_hs_read_init (
    .clk(clk), .rst_n(rst_n), .cfg_wait_limit(lim),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .bus_free(bus_free), .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
    .bus_req(bus_req), .bus_ack_i(ack_line), .bus_ack_o(bus_ack_o),
    .bus_ack_oe(bus_ack_oe), .bus_rdy(tgt_rdy), .bus_data(data_line)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- reference model (0 idle,1 wfree,2 addr,3 req,4 rel,5 wrdy,6 ackh,7 ackl,8 fail)
  int          m_st = 0, m_cnt = 0;
  logic [15:0] m_addr = 0, m_data = 0;
  bit          q_free [$];   // R8: two-entry delay lines stand in for the synchronisers
  bit          q_ack  [$];
  bit          q_rdy  [$];
  initial begin q_free = '{0, 0}; q_ack = '{0, 0}; q_rdy = '{0, 0}; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_addr = 0; m_data = 0;
      q_free = '{0, 0}; q_ack = '{0, 0}; q_rdy = '{0, 0};
    end else begin
      bit f, a, r, ex;
      int n;
      f = q_free[0]; a = q_ack[0]; r = q_rdy[0];
      ex = (lim != 0) && (m_cnt == lim - 1);
      n = m_st;
      case (m_st)
        0: if (cmd_valid) begin n = 1; m_addr = cmd_addr; end
        1: n = f ? 2 : (ex ? 8 : 1);
        2: n = 3;
        3: n = a ? 4 : (ex ? 8 : 3);
        4: n = !a ? 5 : (ex ? 8 : 4);
        5: if (r) begin n = 6; m_data = data_line; end else if (ex) n = 8;
        6: n = !r ? 7 : (ex ? 8 : 6);
        default: n = 0;
      endcase
      if (n != m_st) m_cnt = 0; else if (m_cnt < 255) m_cnt++;
      m_st = n;
      void'(q_free.pop_front()); q_free.push_back(bus_free);
      void'(q_ack.pop_front());  q_ack.push_back(ack_line);
      void'(q_rdy.pop_front());  q_rdy.push_back(tgt_rdy);
    end
  end

  // ---------------- target model
  int   t_st = 0, t_cnt = 0, t_dly = 0, t_hang = -1, t_raise = 0;
  bit   t_seen = 0, t_clear = 0;
  logic [15:0] t_addr = 0;
  bit   free_low_drive = 0;

  always @(negedge clk) begin
    cyc++;
    // compare against the model on every cycle
    begin
      bit e_aoe, e_ackoe;
      e_aoe   = (m_st == 2 || m_st == 3);
      e_ackoe = (m_st >= 5 && m_st <= 7);
      chk(cmd_ready == (m_st == 0), "R1 cmd_ready", cmd_ready, m_st == 0);
      chk(bus_addr_oe == e_aoe, "R2 R3 R10 bus_addr_oe", bus_addr_oe, e_aoe);
      if (e_aoe) chk(bus_addr == m_addr, "R3 bus_addr", bus_addr, m_addr);
      chk(bus_req == (m_st == 3), "R3 R4 bus_req", bus_req, m_st == 3);
      chk(bus_ack_oe == e_ackoe, "R5 R10 bus_ack_oe", bus_ack_oe, e_ackoe);
      if (e_ackoe) chk(bus_ack_o == (m_st == 6), "R5 R6 bus_ack_o", bus_ack_o, m_st == 6);
      chk(rsp_valid == (m_st == 7 || m_st == 8), "R7 R9 rsp_valid", rsp_valid, m_st == 7 || m_st == 8);
      chk(rsp_err == (m_st == 8), "R9 rsp_err", rsp_err, m_st == 8);
      if (m_st == 7) chk(rsp_data == m_data, "R6 R7 rsp_data", rsp_data, m_data);
      if (free_low_drive) chk(!bus_addr_oe && !bus_req, "R2 drive while busy", bus_addr_oe, 0);
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
    if (t_clear) begin
      t_clear = 0; t_st = 0; t_cnt = 0; t_hang = -1; tgt_ack = 0; tgt_rdy = 0;
    end else if (t_st != t_hang) begin
      case (t_st)
        0: if (bus_req) begin
             if (t_cnt >= t_dly) begin
               t_addr = bus_addr; tgt_ack = 1; t_raise = cyc; t_st = 1; t_cnt = 0; t_seen = 0;
             end else t_cnt++;
           end else t_cnt = 0;
        1: if (!bus_req) begin
             if (!t_seen) begin
               t_seen = 1;  // R8: ack change visible at request three edges later
               chk(cyc - t_raise == 3, "R8 latency", cyc - t_raise, 3);
             end
             if (t_cnt >= t_dly) begin tgt_ack = 0; t_st = 2; t_cnt = 0; end else t_cnt++;
           end
        2: if (t_cnt >= t_dly) begin
             tgt_data = t_addr ^ KEY; tgt_rdy = 1; t_st = 3; t_cnt = 0;
           end else t_cnt++;
        3: if (ack_line) begin
             if (t_cnt >= t_dly) begin tgt_rdy = 0; t_st = 4; t_cnt = 0; end else t_cnt++;
           end
        4: if (!ack_line) t_st = 0;
        default: t_st = 0;
      endcase
    end
  end

  // ---------------- stimulus
  task automatic send(input logic [15:0] a);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_rsp(output bit err, output logic [15:0] d);
    err = 1; d = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rsp_valid) begin err = rsp_err; d = rsp_data; return; end
    end
  endtask

  task automatic good_read(input logic [15:0] a, input string tag);
    bit e; logic [15:0] d;
    send(a);
    wait_rsp(e, d);
    chk(e == 0, tag, e, 0);
    chk(d == (a ^ KEY), tag, d, a ^ KEY);
  endtask

  initial begin
    bit e; logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !bus_req && !bus_addr_oe && !bus_ack_oe, "R1 R10 reset state", cmd_ready, 1);

    t_dly = 0; good_read(16'h1234, "R7 fast read");

    // R2: bus not available
    t_dly = 3; bus_free = 0;
    send(16'hBEEF);
    repeat (2) @(negedge clk);
    free_low_drive = 1;
    repeat (20) @(negedge clk);
    free_low_drive = 0;
    bus_free = 1;
    wait_rsp(e, d);
    chk(!e && d == (16'hBEEF ^ KEY), "R2 read after bus freed", d, 16'hBEEF ^ KEY);

    // R9: limit 0 waits without end
    bus_free = 0;
    send(16'h0F0F);
    repeat (300) @(negedge clk);
    chk(!rsp_valid && !cmd_ready, "R9 no abort with zero limit", rsp_valid, 0);
    bus_free = 1;
    wait_rsp(e, d);
    chk(!e && d == (16'h0F0F ^ KEY), "R9 zero limit completes", d, 16'h0F0F ^ KEY);

    // R1: command while busy is dropped
    t_dly = 2;
    send(16'h4321);
    repeat (4) @(negedge clk);
    cmd_valid = 1; cmd_addr = 16'h7777;
    wait_rsp(e, d);
    cmd_valid = 0;
    chk(!e && d == (16'h4321 ^ KEY), "R1 busy command ignored", d, 16'h4321 ^ KEY);
    repeat (10) @(negedge clk);
    chk(cmd_ready && !bus_addr_oe && !bus_req, "R1 no second read started", bus_addr_oe, 0);

    // R9: abort while waiting for acknowledge
    lim = 8'd6; t_hang = 0;
    send(16'h0101);
    wait_rsp(e, d);
    chk(e == 1, "R9 abort on missing ack", e, 1);
    t_clear = 1; repeat (4) @(negedge clk);

    // R9: abort while waiting for ready to fall
    t_hang = 3;
    send(16'h0202);
    wait_rsp(e, d);
    chk(e == 1, "R9 abort on stuck ready", e, 1);
    t_clear = 1; repeat (6) @(negedge clk);

    // R9: abort while bus stays taken
    lim = 8'd5; bus_free = 0;
    send(16'h0303);
    wait_rsp(e, d);
    chk(e == 1, "R9 abort on busy bus", e, 1);
    bus_free = 1;

    // back-to-back reads with varied target delays
    lim = 8'd40;
    for (int i = 0; i < 6; i++) begin
      t_dly = i;
      good_read(16'(16'h1000 + i * 16'h0111), "R6 R7 varied delay read");
    end

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule